// File: doc/BRIEF.md
# Setup Frame Address Filter

This block holds a table of perfect-match destination addresses and decides, for every received frame, whether its 48-bit destination should be accepted. The table is not loaded through registers. It is loaded from a fixed-length setup frame that travels down the transmit byte stream. The transmit path marks such a frame with a setup flag on every byte. The frame is 192 bytes long. It is cut into 4-byte slots, and each slot carries one 16-bit piece of an address in its first two bytes. Its last two bytes are padding and are thrown away. Three slots make one address, so the frame fills sixteen table entries. By convention the station's own address sits in entry 0. The loader pads unused entries with 0xFF bytes, which turns them into the broadcast address.

Filling happens in a shadow table. The table used for decisions is replaced in one step, and only when the final byte of a complete frame arrives. Lookups made while a load is in flight see the previous table. A mode input accepts every frame whose destination has the group bit set. When a load finishes, the block raises a one-cycle completion strobe carrying a fixed status word.

Top module: `setup_addr_filter`

## Requirements
- R1: After reset, every table entry equals the broadcast address 0xFFFFFFFFFFFF. `dec_valid` and `done_valid` are low and `done_status` reads 0.
- R2: A lookup raised with `rx_valid` in cycle t yields `dec_valid` high in cycle t+1, together with its decision on `dec_accept`. `dec_valid` is low in every cycle that does not follow a lookup, and `dec_accept` is low whenever `dec_valid` is low.
- R3: With the multicast mode off, a destination is accepted exactly when it equals one of the 16 table entries. A destination that differs from every entry in at least one bit is rejected.
- R4: Setup byte index i (0..191) belongs to entry i/12, slot (i%12)/4 and position i%4. Positions 0 and 1 load address octet 2*slot+position, and positions 2 and 3 are ignored. Address octet k sits on `rx_dest[8k+7:8k]`, so octet 0 is the first on the wire.
- R5: Entries that were loaded with all-0xFF bytes match broadcast frames. When no entry is all ones, a broadcast destination is rejected unless the multicast mode accepts it.
- R6: While `pass_mcast` is high, every destination with group bit `rx_dest[0]` set is accepted. Destinations with that bit clear still need a table match.
- R7: In the cycle after the 192nd byte of a setup frame is taken, `done_valid` is high for exactly one cycle and `done_status` is 0x7FFFFFFF. At all other times `done_valid` is low and `done_status` is 0.
- R8: The table used for decisions changes only at the completion of a full frame, and it changes in a single step. A lookup made in or before the cycle of the final byte uses the old table. A lookup made from the completion cycle onward uses the new table.
- R9: Bytes with `sf_setup` low are ignored. While no load is in progress, setup bytes without `sf_first` are also ignored. Neither kind starts a load or changes the table.
- R10: A byte with `sf_first` that arrives in the middle of a load restarts the load at index 0. The partial frame is discarded and no completion is reported for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | A transmit-stream byte is present |
| sf_setup | input | 1 | The present byte belongs to a setup frame |
| sf_first | input | 1 | The present byte is byte 0 of a frame |
| sf_data | input | 8 | Transmit-stream byte |
| pass_mcast | input | 1 | Accept every group-addressed destination |
| rx_valid | input | 1 | Lookup request for a received frame |
| rx_dest | input | 48 | Destination address, octet k on bits 8k+7:8k |
| dec_valid | output | 1 | Decision is present |
| dec_accept | output | 1 | Frame accepted |
| done_valid | output | 1 | Setup load completed, one cycle |
| done_status | output | 32 | Completion status word, 0x7FFFFFFF when done_valid is high |

## Verification
The bench loads a table whose entries differ from one another in several octets and pads it with junk bytes. It then queries every entry and every single-bit flip of every entry. This separates a correct exact compare from one that drops a bit, misplaces an octet or reads a padding byte. Group-bit sweeps with the mode on and off show whether the multicast path depends only on bit 0. Setup frames that are unflagged, frames that start without a first-byte marker, and frames that are aborted and restarted are each followed by lookups. A lookup placed on the final byte of a load shows whether the table is swapped at the right cycle, and full-table loads without broadcast entries show whether broadcast acceptance comes only from padded entries.

// File: rtl/sfaf_pkg.sv
`timescale 1ns/1ps
package sfaf_pkg;

  localparam int unsigned OCTETS      = 6;
  localparam int unsigned SLOT_BYTES  = 4;
  localparam int unsigned PIECE_BYTES = 2;
  localparam int unsigned ENTRY_BYTES = (OCTETS / PIECE_BYTES) * SLOT_BYTES;
  localparam int unsigned GROUP_BIT   = 0;
  localparam logic [31:0] DONE_WORD   = 32'h7FFF_FFFF;

  typedef logic [8*OCTETS-1:0] mac_t;

  // entry number that owns setup byte idx
  function automatic int unsigned byte_entry(input int unsigned idx);
    return idx / ENTRY_BYTES;
  endfunction

  // true when setup byte idx carries address data (not slot padding)
  function automatic logic byte_is_addr(input int unsigned idx);
    return (idx % SLOT_BYTES) < PIECE_BYTES;
  endfunction

  // address octet loaded by setup byte idx
  function automatic int unsigned byte_octet(input int unsigned idx);
    return ((idx % ENTRY_BYTES) / SLOT_BYTES) * PIECE_BYTES + (idx % SLOT_BYTES);
  endfunction

endpackage

// File: rtl/sfaf_loader.sv
`timescale 1ns/1ps
module sfaf_loader
  import sfaf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sf_valid,
  input  logic                          sf_setup,
  input  logic                          sf_first,
  input  logic [7:0]                    sf_data,
  output logic [NUM_ENTRIES-1:0][47:0]  shadow_tab,
  output logic                          commit
);
  localparam int FRAME_BYTES = NUM_ENTRIES * ENTRY_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
  localparam int ENT_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] idx;
  logic             take;
  logic             wr_en;
  logic [ENT_W-1:0] wr_ent;
  logic [2:0]       wr_oct;

  always_comb begin
    take   = sf_valid && sf_setup && (sf_first || busy);
    idx    = sf_first ? '0 : cnt;
    commit = take && (idx == LAST_IDX);
    wr_en  = take && byte_is_addr(32'(idx));
    wr_ent = ENT_W'(byte_entry(32'(idx)));
    wr_oct = 3'(byte_octet(32'(idx)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      shadow_tab <= '1;
    end else if (take) begin
      if (commit) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        busy <= 1'b1;
        cnt  <= idx + 1'b1;
      end
      if (wr_en) shadow_tab[wr_ent][{wr_oct, 3'b000} +: 8] <= sf_data;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_IDX); // R4
  AST_LAST_IS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wr_en); // R7
  AST_RESTART_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && sf_setup && sf_first) |=> (cnt == CNT_W'(1))); // R10
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(sf_valid && sf_setup && sf_first)) |=> (cnt == '0)); // R9

endmodule

// File: rtl/sfaf_table.sv
`timescale 1ns/1ps
module sfaf_table #(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [NUM_ENTRIES-1:0][47:0]  shadow_tab,
  output logic [NUM_ENTRIES-1:0][47:0]  active_tab
);

  always_ff @(posedge clk) begin
    if (!rst_n)      active_tab <= '1;
    else if (commit) active_tab <= shadow_tab;
  end

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_tab)); // R8

endmodule

// File: rtl/sfaf_match.sv
`timescale 1ns/1ps
module sfaf_match
  import sfaf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx_valid,
  input  logic [47:0]                   rx_dest,
  input  logic                          pass_mcast,
  input  logic [NUM_ENTRIES-1:0][47:0]  active_tab,
  output logic                          dec_valid,
  output logic                          dec_accept
);
  logic [NUM_ENTRIES-1:0] hit;
  logic                   any_hit;
  logic                   mcast_ok;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign hit[e] = (active_tab[e] == rx_dest);
  end

  assign any_hit  = |hit;
  assign mcast_ok = pass_mcast && rx_dest[GROUP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= rx_valid;
      dec_accept <= rx_valid && (any_hit || mcast_ok);
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> dec_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !dec_valid); // R2
  AST_QUIET_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept); // R2
  AST_MCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pass_mcast && rx_dest[GROUP_BIT]) |=> dec_accept); // R6

endmodule

// File: rtl/setup_addr_filter.sv
`timescale 1ns/1ps
module setup_addr_filter
  import sfaf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sf_valid,
  input  logic        sf_setup,
  input  logic        sf_first,
  input  logic [7:0]  sf_data,
  input  logic        pass_mcast,
  input  logic        rx_valid,
  input  logic [47:0] rx_dest,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        done_valid,
  output logic [31:0] done_status
);
  logic [NUM_ENTRIES-1:0][47:0] shadow_tab;
  logic [NUM_ENTRIES-1:0][47:0] active_tab;
  logic                         commit;

  sfaf_loader #(.NUM_ENTRIES(NUM_ENTRIES)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .sf_valid   (sf_valid),
    .sf_setup   (sf_setup),
    .sf_first   (sf_first),
    .sf_data    (sf_data),
    .shadow_tab (shadow_tab),
    .commit     (commit)
  );

  sfaf_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .shadow_tab (shadow_tab),
    .active_tab (active_tab)
  );

  sfaf_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_dest    (rx_dest),
    .pass_mcast (pass_mcast),
    .active_tab (active_tab),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_valid <= 1'b0;
    else        done_valid <= commit;
  end

  assign done_status = done_valid ? DONE_WORD : 32'h0;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R7
  AST_DONE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(sf_valid && sf_setup)); // R9

endmodule

// File: tb/setup_addr_filter_bench.sv
`timescale 1ns/1ps
module setup_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sf_valid, sf_setup, sf_first;
  logic [7:0]  sf_data;
  logic        pass_mcast, rx_valid;
  logic [47:0] rx_dest;
  logic        dec_valid, dec_accept, done_valid;
  logic [31:0] done_status;

  always #2 clk = ~clk;

  setup_addr_filter u_setup_addr_filter (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_setup(sf_setup),
    .sf_first(sf_first), .sf_data(sf_data), .pass_mcast(pass_mcast),
    .rx_valid(rx_valid), .rx_dest(rx_dest), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .done_valid(done_valid), .done_status(done_status)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [47:0] new_tab [16];
  logic [47:0] ref_tab [16];
  logic [47:0] tab_a [16];
  logic [47:0] tab_b [16];
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_addr(input int e, input int salt);
    logic [7:0] o0, o1, o2, o3, o4, o5;
    o0 = 8'((e * 4 + 2) ^ (salt * 16)) & 8'hFE;
    o1 = 8'(e * 29 + salt * 7 + 1);
    o2 = 8'(e | (salt << 5));
    o3 = 8'h5C ^ 8'(salt);
    o4 = 8'(e * 37 + 11);
    o5 = 8'(salt * 91 + e);
    return {o5, o4, o3, o2, o1, o0};
  endfunction

  // R4 layout: entry i/12, slot (i%12)/4, position i%4; positions 2,3 are padding
  function automatic logic [7:0] frame_byte(input int i);
    int e, r, s, p;
    e = i / 12; r = i % 12; s = r / 4; p = r % 4;
    if (p < 2) return new_tab[e][(s * 2 + p) * 8 +: 8];
    return 8'(8'hC3 ^ i);
  endfunction

  function automatic logic exp_accept(input logic [47:0] d, input logic mc);
    foreach (ref_tab[k]) if (ref_tab[k] == d) return 1'b1;
    return mc & d[0];
  endfunction

  task automatic query(input logic [47:0] d, input string req);
    @(negedge clk);
    rx_valid = 1'b1; rx_dest = d;
    @(negedge clk);
    rx_valid = 1'b0;
    check({req, " dec_valid"}, 64'(dec_valid), 64'd1);
    check(req, 64'(dec_accept), 64'(exp_accept(d, pass_mcast)));
  endtask

  task automatic send_stream(input int nbytes, input bit setup, input bit use_first,
                             input bit probe, input logic [47:0] paddr);
    bit exp_done;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      if (i > 0) check("R7 no early done", 64'(done_valid), 64'd0);
      sf_valid = 1'b1; sf_setup = setup; sf_first = use_first && (i == 0);
      sf_data = frame_byte(i);
      if (probe && i == nbytes - 1) begin
        rx_valid = 1'b1; rx_dest = paddr;
      end
    end
    @(negedge clk);
    sf_valid = 1'b0; sf_first = 1'b0; sf_setup = 1'b0;
    if (probe) begin
      rx_valid = 1'b0;
      check("R8 lookup on last byte uses old table", 64'(dec_accept),
            64'(exp_accept(paddr, pass_mcast)));
    end
    exp_done = setup && use_first && (nbytes == 192);
    check("R7 R9 R10 done strobe", 64'(done_valid), 64'(exp_done));
    check("R7 done status", 64'(done_status), exp_done ? 64'h7FFF_FFFF : 64'h0);
    if (exp_done) foreach (ref_tab[k]) ref_tab[k] = new_tab[k];
    @(negedge clk);
    check("R7 done lasts one cycle", 64'(done_valid), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; sf_valid = 1'b0; sf_setup = 1'b0; sf_first = 1'b0; sf_data = '0;
    pass_mcast = 1'b0; rx_valid = 1'b0; rx_dest = '0;
    foreach (ref_tab[k]) ref_tab[k] = BCAST;
    for (int e = 0; e < 16; e++) begin
      tab_a[e] = (e >= 14) ? BCAST : mk_addr(e, 1);
      tab_b[e] = mk_addr(e, 2);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dec_valid after reset", 64'(dec_valid), 64'd0);
    check("R1 done_valid after reset", 64'(done_valid), 64'd0);
    check("R1 done_status after reset", 64'(done_status), 64'd0);
    query(BCAST, "R1 R5 broadcast after reset");
    query(mk_addr(0, 1), "R1 unicast after reset");

    // load table A (two padded broadcast entries)
    foreach (new_tab[k]) new_tab[k] = tab_a[k];
    send_stream(192, 1'b1, 1'b1, 1'b0, '0);
    for (int e = 0; e < 16; e++) begin
      query(tab_a[e], "R3 R4 entry match");
      for (int b = 0; b < 48; b++)
        query(tab_a[e] ^ (48'd1 << b), "R3 R4 single bit flip");
    end
    query(BCAST, "R5 broadcast via padded entry");

    // multicast mode
    pass_mcast = 1'b1;
    for (int k = 0; k < 32; k++) begin
      query(mk_addr(k + 40, 9) | 48'd1, "R6 group bit accepted");
      query(mk_addr(k + 40, 9), "R6 individual address rejected");
    end
    query(tab_a[4], "R6 table match in mode");
    pass_mcast = 1'b0;
    query(mk_addr(50, 9) | 48'd1, "R6 mode off group rejected");

    // ignored streams
    foreach (new_tab[k]) new_tab[k] = tab_b[k];
    send_stream(192, 1'b0, 1'b1, 1'b0, '0);
    query(tab_b[0], "R9 unflagged frame not loaded");
    query(tab_a[3], "R9 old table kept");
    send_stream(192, 1'b1, 1'b0, 1'b0, '0);
    query(tab_b[1], "R9 no first marker not loaded");
    query(tab_a[5], "R9 old table kept after unmarked");

    // aborted load, then restart with table C (no broadcast entries)
    send_stream(100, 1'b1, 1'b1, 1'b0, '0);
    query(tab_b[2], "R8 R10 partial load invisible");
    query(tab_a[2], "R8 R10 old table during load");
    for (int e = 0; e < 16; e++) new_tab[e] = mk_addr(e, 3);
    send_stream(192, 1'b1, 1'b1, 1'b1, mk_addr(5, 3));
    query(mk_addr(5, 3), "R8 R10 new table after completion");
    query(tab_a[0], "R8 old entry replaced");
    query(tab_b[2], "R10 discarded partial entry");
    query(BCAST, "R5 broadcast rejected without padded entry");
    for (int e = 0; e < 16; e++) query(mk_addr(e, 3), "R3 full table C match");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule